// File: doc/BRIEF.md
# Status Packet Byte Serializer

This block frames a 26-bit status word into a five-byte packet for a shared byte-wide status bus. When a report is due it raises a request and puts a fixed register-address byte on its output. It holds that byte until the downstream side acknowledges it. The acknowledge starts a stream with no further handshake. On the next four clocks the block sends one byte that packs a 6-bit sequence number with the two lowest payload bits, and then three bytes of the remaining payload bits.

A control byte, written through a write strobe, picks when reports are made: never, once per write, whenever the payload moves away from the last value reported, or back-to-back without pause. The same write presets the sequence number, which then counts completed packets. The payload is latched at the acknowledge, so a packet is always one consistent snapshot. Arbitration between several such sources and clock-domain crossing of the payload belong to the surrounding logic.

Top module: `status_pkt_ser`

## Requirements
- R1: After the asynchronous reset rst_ni, rq_o is 0, ad_o is 0, the mode is off and the sequence number is 0. The last captured payload is also 0.
- R2: In mode 0 (control bits [1:0] = 0), rq_o stays 0 whatever the payload does.
- R3: A control write (ctl_we_i) loads the mode from ctl_wd_i[1:0] and presets the sequence number from ctl_wd_i[7:2]. A write takes priority over the end-of-packet increment in the same cycle.
- R4: While rq_o is 1, ad_o equals the parameter ADDR. The request stays up until it is acknowledged.
- R5: When ack_i is 1 in a cycle with rq_o = 1, rq_o is 0 from the next cycle on. ad_o then carries four bytes on the next four clocks, in order: {seq, p[1:0]}, p[9:2], p[17:10], p[25:18], with the sequence number in bits [7:2].
- R6: The payload p sent is the value of payload_i in the acknowledge cycle. Changes to payload_i during the stream do not alter it.
- R7: The sequence number increments by one after the last byte of each packet and wraps from 63 to 0.
- R8: Mode 1 produces exactly one packet per control write that selects it. After that packet, rq_o stays 0.
- R9: In mode 2, rq_o is 1 while idle whenever payload_i differs from the last captured payload.
- R10: In mode 3, rq_o rises again in the cycle right after the last byte of a packet.
- R11: An ack_i while rq_o is 0 is ignored. Whenever no request is up and no packet is streaming, ad_o is 0.
- R12: The synchronous clear srst_i, sampled at a clock edge, returns the block to the state of R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| srst_i | input | 1 | Synchronous clear, active high |
| ctl_we_i | input | 1 | Control byte write strobe |
| ctl_wd_i | input | 8 | Control byte: [1:0] mode, [7:2] sequence preset |
| payload_i | input | 26 | Status word to report |
| ack_i | input | 1 | Acceptance of the address byte |
| rq_o | output | 1 | Bus request |
| ad_o | output | 8 | Packet byte output |

## Verification
rq_o and the address byte follow a control write or a payload change one clock later, or within the same cycle when only payload_i moves in mode 2. Data byte k of a packet appears k clocks after the acknowledge edge, and the sequence number advances at the edge that ends byte 4. The bench drives inputs on the falling edge and samples outputs one time unit later. Each expected byte is therefore compared in the exact low phase that the requirement names. The bench's own sequence counter and captured payload predict every byte, including after random payload changes in the middle of a stream.

// File: rtl/status_pkt_pkg.sv
package status_pkt_pkg;
  localparam int PAYLOAD_W = 26;
  localparam int BYTE_W    = 8;
  localparam int LOW_BITS  = 2;
  localparam int SEQ_W     = BYTE_W - LOW_BITS;
  localparam int PKT_BYTES = 2 + (PAYLOAD_W - LOW_BITS) / BYTE_W;
  localparam int PH_W      = $clog2(PKT_BYTES);

  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_ONCE = 2'd1,
    MODE_CHG  = 2'd2,
    MODE_RUN  = 2'd3
  } rep_mode_e;
endpackage

// File: rtl/status_pkt_ctl.sv
module status_pkt_ctl
  import status_pkt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             srst_i,
  input  logic             we_i,
  input  logic [BYTE_W-1:0] wd_i,
  input  logic             start_i,
  input  logic             done_i,
  output rep_mode_e        mode_o,
  output logic [SEQ_W-1:0] seq_o,
  output logic             once_pend_o
);
  rep_mode_e        mode_q;
  logic [SEQ_W-1:0] seq_q;
  logic             pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_OFF;
      seq_q  <= '0;
      pend_q <= 1'b0;
    end else if (srst_i) begin
      mode_q <= MODE_OFF;
      seq_q  <= '0;
      pend_q <= 1'b0;
    end else if (we_i) begin
      mode_q <= rep_mode_e'(wd_i[LOW_BITS-1:0]);
      seq_q  <= wd_i[BYTE_W-1:LOW_BITS];
      pend_q <= (wd_i[LOW_BITS-1:0] == MODE_ONCE);
    end else begin
      if (done_i)  seq_q  <= seq_q + 1'b1;
      if (start_i) pend_q <= 1'b0;
    end
  end

  assign mode_o      = mode_q;
  assign seq_o       = seq_q;
  assign once_pend_o = pend_q;

  AST_SEQ_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni || srst_i)
    (done_i && !we_i) |=> (seq_q == $past(seq_q) + 1'b1)); // R7
  AST_WRITE_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni || srst_i)
    we_i |=> (seq_q == $past(wd_i[BYTE_W-1:LOW_BITS]))); // R3
endmodule

// File: rtl/status_pkt_framer.sv
module status_pkt_framer
  import status_pkt_pkg::*;
#(
  parameter logic [BYTE_W-1:0] ADDR = 8'h20
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 srst_i,
  input  logic                 want_i,
  input  logic                 ack_i,
  input  logic [PAYLOAD_W-1:0] payload_i,
  input  logic [SEQ_W-1:0]     seq_i,
  output logic                 rq_o,
  output logic                 start_o,
  output logic                 done_o,
  output logic [PAYLOAD_W-1:0] hold_o,
  output logic [BYTE_W-1:0]    ad_o
);
  logic [PH_W-1:0]      phase_q;
  logic [PAYLOAD_W-1:0] hold_q;
  logic [BYTE_W-1:0]    pkt_b [PKT_BYTES];
  logic                 idle;

  assign idle    = (phase_q == '0);
  assign rq_o    = idle && want_i;
  assign start_o = rq_o && ack_i;
  assign done_o  = (phase_q == PH_W'(PKT_BYTES-1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      hold_q  <= '0;
    end else if (srst_i) begin
      phase_q <= '0;
      hold_q  <= '0;
    end else if (start_o) begin
      phase_q <= PH_W'(1);
      hold_q  <= payload_i;
    end else if (!idle) begin
      phase_q <= done_o ? '0 : phase_q + 1'b1;
    end
  end

  assign pkt_b[0] = ADDR;
  assign pkt_b[1] = {seq_i, hold_q[LOW_BITS-1:0]};
  for (genvar k = 2; k < PKT_BYTES; k++) begin : g_data
    assign pkt_b[k] = hold_q[LOW_BITS + BYTE_W*(k-2) +: BYTE_W];
  end

  always_comb begin
    if (rq_o)      ad_o = pkt_b[0];
    else if (idle) ad_o = '0;
    else           ad_o = pkt_b[phase_q];
  end

  assign hold_o = hold_q;

  AST_RQ_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni || srst_i)
    (rq_o && ack_i) |=> !rq_o); // R5
  AST_LOW_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni || srst_i)
    (rq_o && ack_i) |=> (ad_o[LOW_BITS-1:0] == $past(payload_i[LOW_BITS-1:0]))); // R6
  AST_PHASE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q < PH_W'(PKT_BYTES)); // R5
  AST_NO_STRAY_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni || srst_i)
    (idle && !rq_o) |=> ($past(ad_o) == '0)); // R11
endmodule

// File: rtl/status_pkt_ser.sv
module status_pkt_ser
  import status_pkt_pkg::*;
#(
  parameter logic [7:0] ADDR = 8'h20
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        srst_i,
  input  logic        ctl_we_i,
  input  logic [7:0]  ctl_wd_i,
  input  logic [25:0] payload_i,
  input  logic        ack_i,
  output logic        rq_o,
  output logic [7:0]  ad_o
);
  rep_mode_e            mode;
  logic [SEQ_W-1:0]     seq;
  logic                 once_pend;
  logic                 want, start, done;
  logic [PAYLOAD_W-1:0] hold;

  status_pkt_ctl u_ctl (
    .clk_i, .rst_ni, .srst_i,
    .we_i       (ctl_we_i),
    .wd_i       (ctl_wd_i),
    .start_i    (start),
    .done_i     (done),
    .mode_o     (mode),
    .seq_o      (seq),
    .once_pend_o(once_pend)
  );

  always_comb begin
    unique case (mode)
      MODE_ONCE: want = once_pend;
      MODE_CHG:  want = (payload_i != hold);
      MODE_RUN:  want = 1'b1;
      default:   want = 1'b0;
    endcase
  end

  status_pkt_framer #(.ADDR(ADDR)) u_framer (
    .clk_i, .rst_ni, .srst_i,
    .want_i   (want),
    .ack_i    (ack_i),
    .payload_i(payload_i),
    .seq_i    (seq),
    .rq_o     (rq_o),
    .start_o  (start),
    .done_o   (done),
    .hold_o   (hold),
    .ad_o     (ad_o)
  );

  AST_OFF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni || srst_i)
    (mode == MODE_OFF) |-> !rq_o); // R2
  AST_ONCE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni || srst_i)
    (mode == MODE_ONCE && start && !ctl_we_i) |=> !once_pend); // R8
endmodule

// File: tb/status_pkt_ser_test.sv
module status_pkt_ser_test;
  localparam int CLK_P = 10;
  localparam logic [7:0] ADDR = 8'h20;

  logic        clk_i = 0, rst_ni = 0, srst_i = 0, ctl_we_i = 0, ack_i = 0;
  logic [7:0]  ctl_wd_i = 0;
  logic [25:0] payload_i = 0;
  logic        rq_o;
  logic [7:0]  ad_o;

  int checks = 0, fails = 0;
  logic [5:0]  seq_m = 0;
  logic [25:0] last_m = 0;
  bit finished = 0;

  status_pkt_ser #(.ADDR(ADDR)) uut (.*);

  always #(CLK_P/2) clk_i = ~clk_i;

  function automatic logic [7:0] exp_byte(logic [25:0] p, logic [5:0] s, int k);
    case (k)
      0: return ADDR;
      1: return {s, p[1:0]};
      2: return p[9:2];
      3: return p[17:10];
      default: return p[25:18];
    endcase
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk_i); #1;
  endtask

  task automatic wr_ctl(logic [7:0] wd);
    @(negedge clk_i);
    ctl_we_i = 1; ctl_wd_i = wd;
    @(negedge clk_i);
    ctl_we_i = 0; #1;
    seq_m = wd[7:2];
  endtask

  // at a low phase with rq expected; wait, ack, check the four data bytes
  task automatic send_pkt(int wait_cyc, bit scramble);
    logic [25:0] p;
    for (int i = 0; i < wait_cyc; i++) begin
      chk(rq_o == 1 && ad_o == ADDR, "R4", {rq_o, ad_o}, {1'b1, ADDR});
      if (scramble) payload_i = 26'($urandom);
      step();
    end
    ack_i = 1; #1;
    chk(rq_o == 1 && ad_o == ADDR, "R4", {rq_o, ad_o}, {1'b1, ADDR});
    p = payload_i;
    last_m = p;
    @(negedge clk_i); ack_i = 0; #1;
    chk(rq_o == 0, "R5", rq_o, 0);
    for (int k = 1; k <= 4; k++) begin
      chk(ad_o == exp_byte(p, seq_m, k), "R5_R6", ad_o, exp_byte(p, seq_m, k));
      if (scramble) payload_i = 26'($urandom);
      if (k < 4) step();
    end
    step();
    seq_m = seq_m + 1; // R7
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    #(CLK_P * 2 + 1);
    // R1 reset state
    chk(rq_o == 0 && ad_o == 0, "R1", {rq_o, ad_o}, 0);
    @(negedge clk_i); rst_ni = 1; #1;
    chk(rq_o == 0 && ad_o == 0, "R1", {rq_o, ad_o}, 0);

    // R2 mode off ignores payload
    for (int i = 0; i < 5; i++) begin
      payload_i = 26'($urandom); step();
      chk(rq_o == 0, "R2", rq_o, 0);
    end

    // R11 ack with no request is ignored
    ack_i = 1; step(); ack_i = 0; step();
    chk(rq_o == 0 && ad_o == 0, "R11", {rq_o, ad_o}, 0);

    // R3 R8 mode 1 with preset sequence 5, request held for 3 cycles
    payload_i = 26'h2ABCDEF;
    wr_ctl({6'd5, 2'd1});
    send_pkt(3, 0);
    chk(seq_m == 6, "R7", seq_m, 6);
    for (int i = 0; i < 4; i++) begin
      chk(rq_o == 0 && ad_o == 0, "R8", {rq_o, ad_o}, 0);
      step();
    end
    wr_ctl({6'd5, 2'd1});
    send_pkt(0, 0);
    chk(rq_o == 0, "R8", rq_o, 0);

    // R9 mode 2: rq only when payload differs from last captured
    wr_ctl({6'd0, 2'd2});
    chk(rq_o == 0, "R9", rq_o, 0);
    payload_i = last_m ^ 26'h1; #1;
    chk(rq_o == 1 && ad_o == ADDR, "R9", {rq_o, ad_o}, {1'b1, ADDR});
    send_pkt(1, 0);
    chk(rq_o == 0, "R9", rq_o, 0);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk_i); payload_i = 26'($urandom); #1;
      chk(rq_o == (payload_i != last_m), "R9", rq_o, payload_i != last_m);
      if (rq_o) send_pkt(0, 0);
    end

    // R10 R7 mode 3, sequence wrap 63 -> 0
    wr_ctl({6'h3f, 2'd3});
    send_pkt(0, 0);
    chk(seq_m == 0, "R7", seq_m, 0);
    chk(rq_o == 1 && ad_o == ADDR, "R10", {rq_o, ad_o}, {1'b1, ADDR});
    send_pkt(0, 0);

    // R6 R10 random: mid-packet payload changes, random wait before ack
    for (int n = 0; n < 30; n++) begin
      chk(rq_o == 1, "R10", rq_o, 1);
      send_pkt(int'($urandom_range(0, 3)), 1);
    end

    // R12 synchronous clear
    @(negedge clk_i); srst_i = 1;
    @(negedge clk_i); srst_i = 0; #1;
    chk(rq_o == 0 && ad_o == 0, "R12", {rq_o, ad_o}, 0);
    payload_i = 26'h3; step();
    chk(rq_o == 0, "R12", rq_o, 0);
    seq_m = 0;
    wr_ctl({6'd0, 2'd1});
    payload_i = 26'h1234567;
    send_pkt(0, 0);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule